// File: doc/BRIEF.md
# Captured-Bus Multiplexed Hex Display Driver

This block samples a 16-bit bus into a holding register when a capture strobe arrives and shows the held value as four hexadecimal characters on a common-cathode seven-segment display. The display's segment lines are shared by all four digits, so the block lights one digit at a time. A free-running scan picks a nibble, decodes it to a glyph and enables that digit's cathode. It then moves on to the next digit.

The scan reads a second copy of the value, called the frame snapshot. The snapshot reloads only when the scan returns from the last digit to the first. A capture that lands in the middle of a scan therefore never shows as a mix of old and new digits. Between two digits every cathode stays off for one dwell period, so the previous glyph cannot bleed onto the next digit. A run-time polarity input inverts all segment outputs, including the decimal point, so the block can drive active-high or active-low segment lines. A per-digit mask lights decimal points.

Top module: `hexscan_display`

## Requirements
- R1: Digit k (enable bit `dig_en_o[k]`) shows nibble `bus[4k+3:4k]`, so digit 0 carries the least significant nibble.
- R2: At most one bit of `dig_en_o` is high at any time. Digits are lit in the order 0, 1, 2, 3 and then back to 0. Every lit period is preceded by one dwell period with all enables low.
- R3: The capture register loads `bus_i` on a clock edge where `cap_stb_i` is high. It keeps its value on every other edge, whatever the bus does.
- R4: The frame snapshot loads from the capture register only on the edge where the scan leaves digit 3 for digit 0. A capture taken mid-frame first appears in the following frame. A capture taken on the wrap edge itself appears one frame later still.
- R5: `seg_o[0]` through `seg_o[6]` are segments a to g. With active-high polarity, the lit sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcfg, A=abcefg, b=cdefg, C=adef, d=bcdeg, E=adefg, F=aefg.
- R6: With `seg_pol_i`=1 a lit segment or decimal point is driven 1. With `seg_pol_i`=0 all eight outputs are inverted.
- R7: `dp_o` is lit while digit k is enabled exactly when `dp_mask_i[k]` is 1.
- R8: Under reset all enables are low and the capture register and snapshot are zero. The first lit digit appears one dwell period after reset is released, and the first frame shows 0000.
- R9: Each digit stays enabled for exactly `DWELL` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_i | input | 16 | Bus value to capture |
| cap_stb_i | input | 1 | Capture strobe, one cycle per capture |
| seg_pol_i | input | 1 | 1: active-high segments, 0: active-low |
| dp_mask_i | input | 4 | Decimal point lit per digit |
| seg_o | output | 7 | Segments a (bit 0) to g (bit 6) |
| dp_o | output | 1 | Decimal point |
| dig_en_o | output | 4 | Cathode enables, one-hot or zero |

## Verification
A capture strobe and the frame wrap can fall on the same clock edge. On that edge the snapshot takes the old captured value while the capture register takes the new one. The bench provokes this by counting `DWELL` cycles from the rise of digit 3's enable and placing a one-cycle strobe on the wrap edge. It then expects one full frame of the previous value followed by a frame of the new one. A separate strobe placed while digit 1 is lit is judged the same way: every digit of the current frame must keep the old glyph.

// File: rtl/hexscan_pkg.sv
// Shared constants and the hexadecimal glyph table for the hex scan display.
// Assumes segment bit order a=bit0 .. g=bit6 and active-high encoding.
package hexscan_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_N = 7;

    // Active-high segment pattern for one hexadecimal nibble.
    function automatic logic [SEG_N-1:0] hex_glyph(input logic [NIB_W-1:0] v);
        logic [SEG_N-1:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h67;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hexscan_prescaler.sv
// Divides the clock into a one-cycle tick every DWELL cycles.
// Assumes DWELL >= 2; the count restarts from zero at reset.
module hexscan_prescaler #(
    parameter int DWELL = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running modulo-DWELL counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/hexscan_sequencer.sv
// Steps the scan through blank/show phases for each digit in ascending order.
// Assumes tick_i is a single-cycle pulse; wrap_o marks leaving the last digit.
module hexscan_sequencer #(
    parameter int N_DIG = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tick_i,
    output logic [((N_DIG > 1) ? $clog2(N_DIG) : 1)-1:0] digit_o,
    output logic                                   wrap_o,
    output logic [N_DIG-1:0]                       dig_en_o
);
    localparam int IDX_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;
    localparam logic [IDX_W-1:0] LAST_DIG = IDX_W'(N_DIG - 1);

    logic [IDX_W-1:0] digit_q;
    logic             show_q;

    // Blank phase then show phase per digit; advance digit after show.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= '0;
            show_q  <= 1'b0;
        end else if (tick_i) begin
            if (show_q) begin
                show_q  <= 1'b0;
                digit_q <= (digit_q == LAST_DIG) ? '0 : digit_q + 1'b1;
            end else begin
                show_q  <= 1'b1;
            end
        end
    end

    assign digit_o = digit_q;
    assign wrap_o  = tick_i && show_q && (digit_q == LAST_DIG);

    for (genvar k = 0; k < N_DIG; k++) begin : g_en
        assign dig_en_o[k] = show_q && (digit_q == IDX_W'(k));
    end

    // R2
    one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en_o));

    // R2
    blank_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en_o != '0) |-> ($past(dig_en_o) == '0 || $past(dig_en_o) == dig_en_o));

endmodule

// File: rtl/hexscan_glyph.sv
// Converts a nibble and decimal-point request into polarity-adjusted outputs.
// Assumes seg_pol_i=1 means a lit segment is driven high.
module hexscan_glyph
    import hexscan_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    input  logic             dp_lit_i,
    input  logic             seg_pol_i,
    output logic [SEG_N-1:0] seg_o,
    output logic             dp_o
);
    logic [SEG_N-1:0] raw;

    // Look up the glyph and apply output polarity to all eight lines.
    always_comb begin
        raw   = hex_glyph(nib_i);
        seg_o = seg_pol_i ? raw : ~raw;
        dp_o  = seg_pol_i ? dp_lit_i : ~dp_lit_i;
    end

endmodule

// File: rtl/hexscan_display.sv
// Captures a bus value on strobe, snapshots it per scan frame and drives a
// multiplexed common-cathode hex display. Assumes one strobe cycle per capture.
module hexscan_display
    import hexscan_pkg::*;
#(
    parameter int N_DIG = 4,
    parameter int DWELL = 1000,
    localparam int BUS_W = N_DIG * 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             cap_stb_i,
    input  logic             seg_pol_i,
    input  logic [N_DIG-1:0] dp_mask_i,
    output logic [6:0]       seg_o,
    output logic             dp_o,
    output logic [N_DIG-1:0] dig_en_o
);
    localparam int IDX_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;

    logic             tick;
    logic             wrap;
    logic [IDX_W-1:0] digit;
    logic [BUS_W-1:0] cap_q;
    logic [BUS_W-1:0] snap_q;
    logic [NIB_W-1:0] nib;

    hexscan_prescaler #(.DWELL(DWELL)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    hexscan_sequencer #(.N_DIG(N_DIG)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .digit_o  (digit),
        .wrap_o   (wrap),
        .dig_en_o (dig_en_o)
    );

    // Capture register: loads the bus on strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (cap_stb_i) cap_q <= bus_i;
    end

    // Frame snapshot: reloads from the capture register only at scan wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    snap_q <= '0;
        else if (wrap) snap_q <= cap_q;
    end

    assign nib = snap_q[digit*NIB_W +: NIB_W];

    hexscan_glyph u_glyph (
        .nib_i     (nib),
        .dp_lit_i  (dp_mask_i[digit]),
        .seg_pol_i (seg_pol_i),
        .seg_o     (seg_o),
        .dp_o      (dp_o)
    );

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb_i |=> (cap_q == $past(bus_i)));

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb_i |=> $stable(cap_q));

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(snap_q));

    // R4
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (snap_q == $past(cap_q)));

endmodule

// File: tb/hexscan_display_tb.sv
module hexscan_display_tb;
    localparam int DWELL = 4;
    localparam int N_DIG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus = '0;
    logic        cap_stb = 1'b0;
    logic        pol = 1'b1;
    logic [3:0]  mask = '0;
    logic [6:0]  seg;
    logic        dp;
    logic [3:0]  dig_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [11:0] exp_q[$];

    always #5 clk = ~clk;

    hexscan_display #(.N_DIG(N_DIG), .DWELL(DWELL)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_i     (bus),
        .cap_stb_i (cap_stb),
        .seg_pol_i (pol),
        .dp_mask_i (mask),
        .seg_o     (seg),
        .dp_o      (dp),
        .dig_en_o  (dig_en)
    );

    // Glyph table from R5, active high, a = bit 0.
    function automatic logic [6:0] ref_glyph(input logic [3:0] v);
        case (v)
            4'h0: return 7'b0111111;
            4'h1: return 7'b0000110;
            4'h2: return 7'b1011011;
            4'h3: return 7'b1001111;
            4'h4: return 7'b1100110;
            4'h5: return 7'b1101101;
            4'h6: return 7'b1111101;
            4'h7: return 7'b0000111;
            4'h8: return 7'b1111111;
            4'h9: return 7'b1100111;
            4'hA: return 7'b1110111;
            4'hB: return 7'b1111100;
            4'hC: return 7'b0111001;
            4'hD: return 7'b1011110;
            4'hE: return 7'b1111001;
            default: return 7'b1110001;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver side: push one frame of expected items (R1, R5, R6, R7).
    task automatic push_frame(input logic [15:0] v);
        for (int k = 0; k < N_DIG; k++) begin
            logic [6:0] g;
            logic       d;
            g = ref_glyph(v[4*k +: 4]);
            d = mask[k];
            if (!pol) begin
                g = ~g;
                d = ~d;
            end
            exp_q.push_back({4'(1 << k), d, g});
        end
    endtask

    // Wait until digit 3 ends and the scan wraps to digit 0.
    task automatic wait_wrap();
        while (dig_en != 4'b1000) @(negedge clk);
        while (dig_en != 4'b0000) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] v);
        bus = v;
        cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0;
        bus = ~v;   // R3: bus moves without strobe, must be ignored
    endtask

    task automatic show_value(input logic [15:0] v, input logic p, input logic [3:0] m);
        pol = p;
        mask = m;
        strobe(v);
        wait_wrap();
        push_frame(v);
        wait_wrap();
    endtask

    // Monitor: pops expected items at the start of each lit period.
    logic [3:0] prev_en = '0;
    int run = 0;
    int zrun = 0;
    bit seen_show = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dig_en != 4'b0000) begin
                if (prev_en == 4'b0000) begin
                    if (seen_show)
                        check(zrun == DWELL, "R2 blank length", zrun, DWELL);
                    run = 1;
                    seen_show = 1;
                    if (exp_q.size() > 0) begin
                        logic [11:0] e;
                        e = exp_q.pop_front();
                        check({dig_en, dp, seg} == e, "R1/R4/R5/R6/R7 digit",
                              int'({dig_en, dp, seg}), int'(e));
                    end
                end else begin
                    run++;
                    if (dig_en != prev_en)
                        check(1'b0, "R2 enable overlap", dig_en, prev_en);
                end
            end else begin
                if (prev_en != 4'b0000) begin
                    check(run == DWELL, "R9 dwell", run, DWELL);
                    zrun = 1;
                end else begin
                    zrun++;
                end
            end
            prev_en = dig_en;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dig_en == 4'b0000, "R8 enables in reset", dig_en, 0);
        rst_n = 1'b1;
        push_frame(16'h0000);   // R8: first frame shows zeros
        repeat (3) @(negedge clk);
        check(dig_en == 4'b0000, "R8 blank before first step", dig_en, 0);
        wait_wrap();

        show_value(16'h3210, 1'b1, 4'b0000);
        show_value(16'h7654, 1'b0, 4'b0101);
        show_value(16'hBA98, 1'b1, 4'b1010);
        show_value(16'hFEDC, 1'b0, 4'b0000);

        // R4: strobe while digit 1 is lit; current frame keeps old value.
        pol = 1'b1;
        mask = 4'b1000;
        push_frame(16'hFEDC);
        while (dig_en != 4'b0010) @(negedge clk);
        strobe(16'h5A5A);
        wait_wrap();
        push_frame(16'h5A5A);
        wait_wrap();

        // R4: strobe on the wrap edge itself; new value waits one frame.
        while (dig_en != 4'b1000) @(negedge clk);
        repeat (DWELL - 1) @(negedge clk);
        strobe(16'hC3C3);
        check(dig_en == 4'b0000, "R4 wrap edge timing", dig_en, 0);
        push_frame(16'h5A5A);
        wait_wrap();
        push_frame(16'hC3C3);
        wait_wrap();

        check(exp_q.size() == 0, "R1 all frames shown", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule